// File: doc/BRIEF.md
# USB Data Packet Transmitter

This block turns a payload held in a byte-wide memory into a complete USB data packet on a byte-serial transmit interface. A start strobe captures a 4-bit data packet identifier and a payload length. The block then sends the identifier byte, then the payload bytes read one at a time from the memory, then two CRC16 check bytes. The CRC is built up byte by byte as the payload leaves, so no pass over the payload happens ahead of time.

The transmit side follows a valid/ready handshake. Each byte stays on the bus until the ready input is sampled high at a clock edge. A zero-length payload is legal. The memory read is combinational: the block drives a byte index and expects that byte back in the same cycle.

Top module: `usb_data_tx`

## Requirements
- R1: While reset is asserted and after it is released, txValid, busy and done are low until a start is accepted.
- R2: A start sampled high while busy is low is accepted. On the next cycle txValid is high and txData carries the identifier in bits 3:0 and its bitwise complement in bits 7:4.
- R3: Payload byte k, for k from 0 to len-1 in that order, is sent while rdAddr equals k, and txData equals rdData unmodified.
- R4: The CRC register starts at 0xFFFF. For each payload byte b, the bits of b are shifted in starting with bit 0. Each shift is: feedback = crc[15] xor bit, then crc = crc<<1, then xor with 0x8005 when feedback is 1. After the payload, the first check byte is the complement of bit-reversed crc[15:8], and the second is the complement of bit-reversed crc[7:0].
- R5: Exactly len+3 bytes are accepted per packet. txValid stays high from the first byte until the last byte is accepted.
- R6: While txValid is high and txReady is low, txData and txValid hold their values. Stall cycles do not change the CRC.
- R7: With len = 0, the packet is the identifier byte followed by two check bytes 0x00, 0x00.
- R8: done is high for exactly one cycle, the cycle after the last byte is accepted. In that cycle busy and txValid are already low.
- R9: A start strobe while busy is high has no effect on the packet in flight and starts no further packet.
- R10: busy is high from the cycle after an accepted start until the last byte is accepted, and it falls only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Packet start strobe |
| pid | input | 4 | Data packet identifier, captured at start |
| payloadLen | input | LEN_W | Payload byte count, captured at start |
| rdAddr | output | LEN_W | Payload memory byte index |
| rdData | input | 8 | Payload byte at rdAddr, same cycle |
| txData | output | 8 | Transmit byte |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Transmit byte accepted at this edge when high with txValid |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench builds the block with LEN_W = 5, so payload lengths run from 0 up to the full count of 31 and both ends of the length range can be tested in a short run. Ready is randomised at several acceptance rates, from always-ready down to heavy stalling. This puts stalls on the identifier, on payload bytes and on both check bytes. Extra start strobes are pushed into packets in flight. Every packet's check bytes are compared against a reflected-form CRC model written separately in the bench.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h8005;

  typedef enum logic [1:0] {
    SEL_PID    = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_CRC_HI = 2'd2,
    SEL_CRC_LO = 2'd3
  } byteSel_e;

  typedef struct packed {
    logic     capture;
    logic     crcStep;
    byteSel_e sel;
  } ctlStrobe_t;

  function automatic logic [7:0] bitRev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // Fold one byte into the CRC, bit 0 of the byte entering first.
  function automatic logic [15:0] crcFold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] acc;
    logic        fb;
    acc = c;
    for (int i = 0; i < 8; i++) begin
      fb  = acc[15] ^ b[i];
      acc = {acc[14:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction

endpackage

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic             txReady,
  output logic             txValid,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] rdAddr,
  output ctlStrobe_t       ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PID, ST_DATA, ST_CRC_HI, ST_CRC_LO
  } state_e;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  state_e           state;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] idx;
  logic             take;

  assign txValid = (state != ST_IDLE);
  assign busy    = txValid;
  assign take    = txValid && txReady;
  assign rdAddr  = idx;

  always_comb begin
    ctl.capture = (state == ST_IDLE) && start;
    ctl.crcStep = (state == ST_DATA) && txReady;
    unique case (state)
      ST_DATA:   ctl.sel = SEL_DATA;
      ST_CRC_HI: ctl.sel = SEL_CRC_HI;
      ST_CRC_LO: ctl.sel = SEL_CRC_LO;
      default:   ctl.sel = SEL_PID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lenQ  <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_CRC_LO) && txReady;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_PID;
          lenQ  <= payloadLen;
          idx   <= '0;
        end
        ST_PID: if (take) state <= (lenQ == '0) ? ST_CRC_HI : ST_DATA;
        ST_DATA: if (take) begin
          if (idx == lenQ - ONE) state <= ST_CRC_HI;
          else                   idx   <= idx + ONE;
        end
        ST_CRC_HI: if (take) state <= ST_CRC_LO;
        ST_CRC_LO: if (take) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_datapath.sv
module usb_tx_datapath
  import usb_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctlStrobe_t ctl,
  input  logic [3:0] pid,
  input  logic [7:0] rdData,
  output logic [7:0] txData
);

  logic [3:0]  pidQ;
  logic [15:0] crcQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidQ <= '0;
      crcQ <= CRC_SEED;
    end else if (ctl.capture) begin
      pidQ <= pid;
      crcQ <= CRC_SEED;
    end else if (ctl.crcStep) begin
      crcQ <= crcFold(crcQ, rdData);
    end
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_DATA:   txData = rdData;
      SEL_CRC_HI: txData = ~bitRev8(crcQ[15:8]);
      SEL_CRC_LO: txData = ~bitRev8(crcQ[7:0]);
      default:    txData = {~pidQ, pidQ};
    endcase
  end

endmodule

// File: rtl/usb_data_tx.sv
module usb_data_tx
  import usb_tx_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       pid,
  input  logic [LEN_W-1:0] payloadLen,
  output logic [LEN_W-1:0] rdAddr,
  input  logic [7:0]       rdData,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic             txReady,
  output logic             busy,
  output logic             done
);

  ctlStrobe_t ctl;

  usb_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .payloadLen(payloadLen),
    .txReady(txReady), .txValid(txValid), .busy(busy), .done(done),
    .rdAddr(rdAddr), .ctl(ctl)
  );

  usb_tx_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pid(pid),
    .rdData(rdData), .txData(txData)
  );

endmodule

// File: rtl/usb_tx_check.sv
module usb_tx_check #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [3:0]       pid,
  input logic [7:0]       txData,
  input logic             txValid,
  input logic             txReady,
  input logic             busy,
  input logic             done
);

  a_r2_pid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (txValid && txData == {~$past(pid), $past(pid)}));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !txValid));

  a_r10_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind usb_data_tx usb_tx_check #(.LEN_W(LEN_W)) u_check (
  .clk(clk), .rst_n(rst_n), .start(start), .pid(pid), .txData(txData),
  .txValid(txValid), .txReady(txReady), .busy(busy), .done(done)
);

// File: tb/usb_data_tx_test.sv
`timescale 1ns/100ps
module usb_data_tx_test;

  localparam int LEN_W = 5;
  localparam int MAXLEN = (1 << LEN_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [3:0]       pid = '0;
  logic [LEN_W-1:0] payloadLen = '0;
  logic [LEN_W-1:0] rdAddr;
  logic [7:0]       rdData;
  logic [7:0]       txData;
  logic             txValid;
  logic             txReady = 1'b0;
  logic             busy;
  logic             done;

  logic [7:0] mem [0:MAXLEN];
  assign rdData = mem[rdAddr];

  int tests = 0;
  int fails = 0;
  int readyPct = 100;
  int doneCnt = 0;
  bit monOn = 0;
  logic [7:0] got [$];
  bit prevStall = 0;
  logic [7:0] prevData = '0;

  always #2.5 clk = ~clk;

  usb_data_tx #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pid(pid), .payloadLen(payloadLen),
    .rdAddr(rdAddr), .rdData(rdData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reflected-form model: shift right, poly 0xA001, byte LSB first.
  function automatic logic [15:0] refCrc(input int len);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = r[0] ^ mem[k][i];
        r = r >> 1;
        if (fb) r = r ^ 16'hA001;
      end
    return ~r;
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      txReady = ($urandom_range(99) < readyPct);
      #0.5;
      if (prevStall) chk(txData === prevData, "R6 hold", txData, prevData);
      if (busy !== txValid) chk(0, "R5/R10 busy vs valid", busy, txValid);
      if (done) begin
        doneCnt++;
        if (busy || txValid) chk(0, "R8 idle at done", busy, 0);
      end
      if (txValid && txReady) got.push_back(txData);
      prevStall = txValid && !txReady;
      prevData  = txData;
    end
  end

  task automatic runPkt(input logic [3:0] p, input int len, input int pct, input bit poke);
    logic [15:0] c;
    int d0;
    readyPct = pct;
    for (int k = 0; k <= MAXLEN; k++) mem[k] = 8'($urandom);
    got.delete();
    d0 = doneCnt;
    @(negedge clk);
    start = 1'b1; pid = p; payloadLen = LEN_W'(len);
    @(negedge clk);
    start = 1'b0; pid = ~p; payloadLen = LEN_W'(MAXLEN - len);
    #1;
    chk(txValid === 1'b1 && txData === {~p, p}, "R2 first byte", txData, {~p, p});
    if (poke) begin
      @(negedge clk);
      if (busy) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    while (doneCnt == d0) @(negedge clk);
    repeat (4) begin
      @(negedge clk); #1;
      if (txValid) chk(0, "R9 no restart", txValid, 0);
    end
    chk(doneCnt == d0 + 1, "R8 one done", doneCnt - d0, 1);
    chk(got.size() == len + 3, "R5 byte count", got.size(), len + 3);
    if (got.size() == len + 3) begin
      chk(got[0] === {~p, p}, "R2 pid byte", got[0], {~p, p});
      for (int k = 0; k < len; k++)
        if (got[k+1] !== mem[k]) chk(0, "R3 payload", got[k+1], mem[k]);
      c = refCrc(len);
      chk({got[len+1], got[len+2]} === {c[7:0], c[15:8]}, "R4 crc bytes",
          {got[len+1], got[len+2]}, {c[7:0], c[15:8]});
      if (len == 0) chk(got[1] === 8'h00 && got[2] === 8'h00, "R7 zero length", {got[1], got[2]}, 0);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(!txValid && !busy && !done, "R1 in reset", {txValid, busy, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!txValid && !busy && !done, "R1 after reset", {txValid, busy, done}, 0);
    monOn = 1;
    runPkt(4'h3, 0, 100, 0);
    runPkt(4'hB, 0, 30, 1);
    runPkt(4'h3, 1, 100, 0);
    runPkt(4'hB, MAXLEN, 100, 1);
    runPkt(4'h3, MAXLEN, 25, 0);
    runPkt(4'h7, 5, 50, 1);
    for (int n = 0; n < 30; n++)
      runPkt(4'($urandom), $urandom_range(MAXLEN), 20 + $urandom_range(80), n[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule